// File: doc/BRIEF.md
# Nearest-Match PLL Divider Search

This block turns a requested pixel clock into a programming word for a frequency synthesizer. The synthesizer divides a fixed reference by (M + 2), multiplies it by (N + 8) and then divides it by a post-divider of 2^K. The request arrives as an unsigned frequency in units of 0.01 MHz together with a one-cycle `start` strobe. The block first forces the request into the synthesizer's usable range. It then picks the post-divider exponent K by doubling the request until it reaches the oscillator floor. Last, it walks every (M, N) pair in a parameterised rectangle and keeps the pair whose output frequency lies closest to the request.

All comparisons take place in a frequency domain scaled by 256. The reference constant is 938356, which is 14.31818 MHz times 65536. Each candidate output is 938356 × (N + 8) / (2^K × 256 × (M + 2)), and a multi-cycle restoring divider computes it one quotient bit per clock. The requested value for comparison is target × 256 / 100. When the walk ends, the block presents the packed word on `prog_word` and pulses `done`.

Top module: `pll_nearest_search`

## Requirements
- R1: A request below 8000 is searched exactly as if it were 8000.
- R2: A request above 15938 is searched exactly as if it were 15938.
- R3: K is the number of doublings needed to bring the clamped request to at least 64000. It appears in `prog_word[7:6]`.
- R4: Each candidate output is floor(938356 × (N + 8) / ((256 << K) × (M + 2))). It is compared with floor(clamped × 256 / 100). Only M in [M_MIN, M_MAX] and N in [N_MIN, N_MAX] are visited.
- R5: The chosen pair has the smallest absolute error. The walk runs M ascending in the outer loop and N ascending in the inner loop. A later pair replaces the stored one only when its error is strictly smaller, so on a tie the first pair found wins. The stored error starts at all ones.
- R6: The result word is N × 256 + K × 64 + M, with M in bits [5:0], K in bits [7:6] and N in bits [15:8]. `done` is high for exactly one cycle, once all candidates have been visited, and `busy` is low in that cycle. `prog_word` changes only in a cycle where `done` is high.
- R7: A `start` pulse while `busy` is high has no effect, and the search already running completes with its own request.
- R8: After reset, `busy`, `done` and `prog_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search with `target_freq` (accepted only when idle) |
| target_freq | input | 16 | Requested frequency in 0.01 MHz units |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when `prog_word` is updated |
| prog_word | output | 16 | Packed {N, K, M} result |

## Verification
The bench builds the block with M limited to 2..5 and N limited to 35..42. That gives 32 candidates per search, so each search finishes in about a thousand cycles. This small rectangle lets the bench sweep requests from well below the lower clamp to well above the upper clamp in a single run. For every request, the bench repeats the whole nested walk in integer arithmetic and compares the full packed word. This covers both clamp edges, the tie rule and the field packing. A second start pulse issued mid-search checks that a running search cannot be redirected.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int FREQ_LO     = 8000;
  localparam int FREQ_HI     = 15938;
  localparam int VCO_FLOOR   = FREQ_LO * 8;
  localparam int REF_SCALED  = 938356;
  localparam int N_OFF       = 8;
  localparam int M_OFF       = 2;
  localparam int K_STEPS     = 3;

  function automatic logic [15:0] clamp_freq(input logic [15:0] t);
    if (t < 16'(FREQ_LO)) return 16'(FREQ_LO);
    if (t > 16'(FREQ_HI)) return 16'(FREQ_HI);
    return t;
  endfunction

  function automatic logic [15:0] scale_cmp(input logic [15:0] t);
    logic [31:0] w;
    w = (32'(t) * 32'd256) / 32'd100;
    return w[15:0];
  endfunction

  function automatic logic [1:0] post_exp(input logic [15:0] t);
    logic [31:0] v;
    logic [1:0]  k;
    v = 32'(t);
    k = 2'd0;
    for (int i = 0; i < K_STEPS; i++) begin
      if (v < 32'(VCO_FLOOR)) begin
        v = v << 1;
        k = k + 2'd1;
      end
    end
    return k;
  endfunction

  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [15:0] pack_word(input logic [1:0] k, input logic [5:0] m,
                                            input logic [7:0] n);
    return {n, k, m};
  endfunction

endpackage

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int NW = 28,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic          fin
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q;
  logic [DW:0]   r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [DW+1:0] shifted;
  logic [DW+1:0] trial;

  assign shifted = {r, q[NW-1]};
  assign trial   = shifted - {2'b00, den};
  assign quo     = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      r   <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        q   <= num;
        r   <= '0;
        cnt <= CW'(NW);
        run <= 1'b1;
      end else if (run) begin
        if (shifted >= {2'b00, den}) begin
          r <= trial[DW:0];
          q <= {q[NW-2:0], 1'b1};
        end else begin
          r <= shifted[DW:0];
          q <= {q[NW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        ev,
  input  logic [31:0] err,
  input  logic [5:0]  m_in,
  input  logic [7:0]  n_in,
  output logic        improve,
  output logic [31:0] best_diff,
  output logic [5:0]  best_m,
  output logic [7:0]  best_n
);
  assign improve = ev && (err < best_diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_diff <= '1;
      best_m    <= '0;
      best_n    <= '0;
    end else if (clr) begin
      best_diff <= '1;
      best_m    <= '0;
      best_n    <= '0;
    end else if (improve) begin
      best_diff <= err;
      best_m    <= m_in;
      best_n    <= n_in;
    end
  end
endmodule

// File: rtl/pll_nearest_search.sv
module pll_nearest_search
  import pll_search_pkg::*;
#(
  parameter int M_MIN = 2,
  parameter int M_MAX = 30,
  parameter int N_MIN = 35,
  parameter int N_MAX = 248
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] target_freq,
  output logic        busy,
  output logic        done,
  output logic [15:0] prog_word
);
  localparam int NUM_W = $clog2(REF_SCALED * (N_MAX + N_OFF) + 1);
  localparam int DEN_W = $clog2((256 << K_STEPS) * (M_MAX + M_OFF) + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT, S_DONE} st_t;

  st_t              state;
  logic [1:0]       k_r;
  logic [15:0]      cmp_r;
  logic [5:0]       m_cur;
  logic [7:0]       n_cur;
  logic             accept;
  logic             div_load;
  logic             div_fin;
  logic [NUM_W-1:0] f_out;
  logic [NUM_W-1:0] num_w;
  logic [DEN_W-1:0] den_w;
  logic             cand_ev;
  logic             last_cand;
  logic             improve;
  logic [31:0]      cand_err;
  logic [31:0]      best_diff;
  logic [5:0]       best_m;
  logic [7:0]       best_n;
  logic [15:0]      clamped;

  assign clamped   = clamp_freq(target_freq);
  assign accept    = start && (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign div_load  = (state == S_LOAD);
  assign cand_ev   = (state == S_WAIT) && div_fin;
  assign last_cand = (m_cur == 6'(M_MAX)) && (n_cur == 8'(N_MAX));
  assign num_w     = NUM_W'(REF_SCALED * (int'(n_cur) + N_OFF));
  assign den_w     = DEN_W'((int'(m_cur) + M_OFF) << (8 + int'(k_r)));
  assign cand_err  = abs_gap(32'(cmp_r), 32'(f_out));

  pll_restoring_div #(.NW(NUM_W), .DW(DEN_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .load (div_load),
    .num  (num_w),
    .den  (den_w),
    .quo  (f_out),
    .fin  (div_fin)
  );

  pll_best_keep u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .ev       (cand_ev),
    .err      (cand_err),
    .m_in     (m_cur),
    .n_in     (n_cur),
    .improve  (improve),
    .best_diff(best_diff),
    .best_m   (best_m),
    .best_n   (best_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      k_r       <= '0;
      cmp_r     <= '0;
      m_cur     <= '0;
      n_cur     <= '0;
      done      <= 1'b0;
      prog_word <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          k_r   <= post_exp(clamped);
          cmp_r <= scale_cmp(clamped);
          m_cur <= 6'(M_MIN);
          n_cur <= 8'(N_MIN);
          state <= S_LOAD;
        end
        S_LOAD: state <= S_WAIT;
        S_WAIT: if (div_fin) begin
          if (last_cand) begin
            state <= S_DONE;
          end else begin
            if (n_cur == 8'(N_MAX)) begin
              n_cur <= 8'(N_MIN);
              m_cur <= m_cur + 6'd1;
            end else begin
              n_cur <= n_cur + 8'd1;
            end
            state <= S_LOAD;
          end
        end
        S_DONE: begin
          prog_word <= pack_word(k_r, best_m, best_n);
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
  parameter int M_MIN = 2,
  parameter int M_MAX = 30,
  parameter int N_MIN = 35,
  parameter int N_MAX = 248
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] prog_word,
  input logic        improve,
  input logic [31:0] best_diff,
  input logic [5:0]  m_cur,
  input logic [7:0]  n_cur
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy));
  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(prog_word));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  // R5
  strict_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    improve |=> (best_diff < $past(best_diff)));
  // R4
  walk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (m_cur >= 6'(M_MIN) && m_cur <= 6'(M_MAX) && n_cur >= 8'(N_MIN) && n_cur <= 8'(N_MAX)));
endmodule

bind pll_nearest_search pll_search_chk #(
  .M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .prog_word(prog_word),
  .improve  (improve),
  .best_diff(best_diff),
  .m_cur    (m_cur),
  .n_cur    (n_cur)
);

// File: tb/pll_nearest_search_bench.sv
module pll_nearest_search_bench;
  localparam int MLO = 2, MHI = 5, NLO = 35, NHI = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] target_freq = '0;
  logic        busy, done;
  logic [15:0] prog_word;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  pll_nearest_search #(.M_MIN(MLO), .M_MAX(MHI), .N_MIN(NLO), .N_MAX(NHI)) u_pll_nearest_search (
    .clk(clk), .rst_n(rst_n), .start(start), .target_freq(target_freq),
    .busy(busy), .done(done), .prog_word(prog_word)
  );

  function automatic int exp_k(int t);
    int c = (t < 8000) ? 8000 : ((t > 15938) ? 15938 : t);
    int k = 0;
    while (c < 64000) begin c = c * 2; k++; end
    return k;
  endfunction

  function automatic int exp_word(int t);
    int c = (t < 8000) ? 8000 : ((t > 15938) ? 15938 : t);
    longint goal = (longint'(c) * 256) / 100;
    int k = exp_k(t);
    longint best = 64'hFFFF_FFFF;
    int bm = 0, bn = 0;
    for (int m = MLO; m <= MHI; m++)
      for (int n = NLO; n <= NHI; n++) begin
        longint f = (longint'(938356) * (n + 8)) / ((longint'(256) << k) * (m + 2));
        longint d = (goal > f) ? goal - f : f - goal;
        if (d < best) begin best = d; bm = m; bn = n; end
      end
    return bn * 256 + k * 64 + bm;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) begin errors++; checks++; $display("FAIL R6: done never seen"); end
  endtask

  task automatic run(string req, int t);
    bit ok;
    @(negedge clk);
    target_freq = 16'(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 busy", int'(busy), 1);
    wait_done(ok);
    if (ok) begin
      check(req, int'(prog_word), exp_word(t));
      check("R6 busy low at done", int'(busy), 0);
      @(negedge clk);
      check("R6 single pulse", int'(done), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 busy", int'(busy), 0);
    check("R8 done", int'(done), 0);
    check("R8 word", int'(prog_word), 0);
    rst_n = 1'b1;

    // R1 low clamp
    run("R1 below floor", 5000);
    check("R1 same as floor", int'(prog_word), exp_word(8000));
    run("R1 zero request", 0);
    run("R1 at floor", 8000);
    // R2 high clamp
    run("R2 above ceiling", 20000);
    check("R2 same as ceiling", int'(prog_word), exp_word(15938));
    run("R2 at ceiling", 15938);
    run("R2 max code", 65535);
    // R3 exponent field
    check("R3 K field", int'(prog_word[7:6]), exp_k(65535));

    // R4 R5 sweep across the range, whole packed word checked
    for (int t = 7600; t <= 16400; t += 400) begin
      run("R5 sweep", t);
      check("R3 K field sweep", int'(prog_word[7:6]), exp_k(t));
    end
    run("R4 odd value", 12345);
    run("R5 odd value", 9999);

    // R7 start while busy is ignored
    @(negedge clk);
    target_freq = 16'd9000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    target_freq = 16'd15000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    target_freq = 16'd0;
    wait_done(ok);
    if (ok) check("R7 first request kept", int'(prog_word), exp_word(9000));
    repeat (5) @(negedge clk);
    check("R7 no second search", int'(busy), 0);
    // R6 word held while idle
    check("R6 word held", int'(prog_word), exp_word(9000));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule